// File: doc/BRIEF.md
# SPI Flash Short-Command Engine

This block is an SPI master that sits behind a window of eight byte-wide host registers. Software fills in an opcode, up to three address bytes and one optional data byte. It then writes a control byte that selects how many bytes go out (1, 2, 4 or 5) and how many come back (0 to 3). The engine drives one chip-select frame in SPI mode 0, most significant bit first. It shifts the reply bytes into read-back registers and holds a busy flag until the frame and a short idle gap are over.

The address registers are stored in the reverse of wire order: the highest window offset goes out first. The last window offset does two jobs. It is the outgoing data byte, and it also receives the third reply byte. A three-byte read therefore replaces the data byte that was written there. The serial clock is the system clock divided by twice `HALF_DIV`.

The sequencer moves through six named states:
- `ST_IDLE` goes to `ST_LEAD` on a valid control write.
- `ST_LEAD` holds chip select low for half a period, then goes to `ST_HIGH`.
- `ST_HIGH` is the clock-high phase. It goes to `ST_LOW` after an ordinary bit, or to `ST_TRAIL` after the last bit of the frame.
- `ST_LOW` goes back to `ST_HIGH`.
- `ST_TRAIL` keeps chip select low for half a period after the last falling edge, then goes to `ST_GAP`.
- `ST_GAP` keeps busy asserted with chip select high for one full SCK period, then returns to `ST_IDLE`.

Top module: `spi_cmd_engine`

## Requirements
- R1: Reading offset 0 returns the busy flag in bit 7, with all other bits 0. Busy reads 1 in the cycle after a start write and reads 0 once the frame and its idle gap are over.
- R2: A control write to offset 0 starts a frame only when bits 7:4 equal 4'h5. Any other value leaves busy at 0 and chip select high.
- R3: Control bits 1:0 select the outgoing bytes, all taken from the window:
  - 0 sends the opcode (offset 1) only.
  - 1 sends the opcode, then the data byte (offset 7).
  - 2 sends the opcode, then offsets 4, 3 and 2 in that order.
  - 3 sends the opcode, offsets 4, 3 and 2, then offset 7.
- R4: Control bits 3:2 give the number of reply bytes, from 0 to 3. These bytes are clocked in after the outgoing bytes, with MOSI held at 0. They land at offsets 5, 6 and 7 in the order received, so a count of 3 overwrites the data byte at offset 7.
- R5: Read-back offsets that a frame does not fill keep their previous contents.
- R6: SPI mode 0 applies. SCK is low whenever chip select is high. MOSI is stable across each rising SCK edge, bits go out MSB first, and MISO is sampled at the rising edge.
- R7: Chip select falls before the first rising SCK edge and rises only after the last one. Each frame carries exactly 8×(write bytes + read bytes) rising edges.
- R8: After chip select rises, busy stays set for exactly 2×HALF_DIV system cycles, one full SCK period.
- R9: Host writes to any offset are ignored while busy is set. This includes a second control write.
- R10: After reset, every offset reads 0, chip select is high and SCK is low.
- R11: Host writes to offsets 5 and 6 are ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write offset |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read offset |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench runs every write-length code. Each one is paired with a different read count, so a mis-decoded length shows up as a wrong rising-edge count on the slave side, and a reversed address order shows up as swapped bytes in the captured stream. A three-byte read checks that offset 7 is overwritten, while shorter reads check that untouched read-back offsets survive: a design that clears unused slots, or writes reply bytes to the wrong slot, fails there. Control writes with a wrong key, and writes made during a running frame, are expected to change nothing. A design that restarts or relatches registers mid-frame would corrupt the stream or the opcode. The idle gap is timed cycle by cycle, so a design that drops busy together with chip select is caught.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;
    localparam int CNT_W  = 4;

    localparam logic [3:0] START_KEY = 4'h5;

    localparam logic [OFS_W-1:0] OFS_CTL   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_OP    = 3'd1;
    localparam logic [OFS_W-1:0] OFS_A_LO  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_A_MID = 3'd3;
    localparam logic [OFS_W-1:0] OFS_A_HI  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_RX0   = 3'd5;
    localparam logic [OFS_W-1:0] OFS_RX1   = 3'd6;
    localparam logic [OFS_W-1:0] OFS_DAT   = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL,
        ST_GAP
    } seq_state_t;

    // outgoing byte count for a 2-bit length code
    function automatic logic [CNT_W-1:0] wr_bytes(input logic [1:0] enc);
        unique case (enc)
            2'd0: wr_bytes = CNT_W'(1);
            2'd1: wr_bytes = CNT_W'(2);
            2'd2: wr_bytes = CNT_W'(4);
            default: wr_bytes = CNT_W'(5);
        endcase
    endfunction

    // byte placed on the wire at position idx of the frame
    function automatic logic [BYTE_W-1:0] tx_pick(
        input logic [CNT_W-1:0]  idx,
        input logic [1:0]        enc,
        input logic [BYTE_W-1:0] op,
        input logic [BYTE_W-1:0] a_hi,
        input logic [BYTE_W-1:0] a_mid,
        input logic [BYTE_W-1:0] a_lo,
        input logic [BYTE_W-1:0] dat
    );
        tx_pick = '0;
        if (idx == 0)
            tx_pick = op;
        else if (enc[1] && idx == CNT_W'(1))
            tx_pick = a_hi;
        else if (enc[1] && idx == CNT_W'(2))
            tx_pick = a_mid;
        else if (enc[1] && idx == CNT_W'(3))
            tx_pick = a_lo;
        else if (enc == 2'd1 && idx == CNT_W'(1))
            tx_pick = dat;
        else if (enc == 2'd3 && idx == CNT_W'(4))
            tx_pick = dat;
    endfunction

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == TOP)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == TOP);

endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [OFS_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0] host_din,
    input  logic              busy,
    input  logic              rx_we,
    input  logic [1:0]        rx_slot,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [OFS_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] op_q,
    output logic [BYTE_W-1:0] a_hi_q,
    output logic [BYTE_W-1:0] a_mid_q,
    output logic [BYTE_W-1:0] a_lo_q,
    output logic [BYTE_W-1:0] dat_q
);
    localparam int NREG = 1 << OFS_W;

    logic [BYTE_W-1:0] q [1:NREG-1];
    logic host_ok;

    assign host_ok = host_we && !busy;

    for (genvar k = 1; k < NREG; k++) begin : g_reg
        if (k == int'(OFS_RX0) || k == int'(OFS_RX1)) begin : g_rx_only
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[k] <= '0;
                else if (rx_we && rx_slot == 2'(k - int'(OFS_RX0)))
                    q[k] <= rx_byte;
            end
        end else if (k == int'(OFS_DAT)) begin : g_shared
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[k] <= '0;
                else if (rx_we && rx_slot == 2'd2)
                    q[k] <= rx_byte;
                else if (host_ok && host_addr == OFS_W'(k))
                    q[k] <= host_din;
            end
        end else begin : g_host_only
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[k] <= '0;
                else if (host_ok && host_addr == OFS_W'(k))
                    q[k] <= host_din;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            OFS_CTL:   rd_data = {busy, {(BYTE_W-1){1'b0}}};
            OFS_OP:    rd_data = q[1];
            OFS_A_LO:  rd_data = q[2];
            OFS_A_MID: rd_data = q[3];
            OFS_A_HI:  rd_data = q[4];
            OFS_RX0:   rd_data = q[5];
            OFS_RX1:   rd_data = q[6];
            default:   rd_data = q[7];
        endcase
    end

    assign op_q    = q[int'(OFS_OP)];
    assign a_hi_q  = q[int'(OFS_A_HI)];
    assign a_mid_q = q[int'(OFS_A_MID)];
    assign a_lo_q  = q[int'(OFS_A_LO)];
    assign dat_q   = q[int'(OFS_DAT)];

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] ctl_din,
    input  logic              miso,
    input  logic [BYTE_W-1:0] op,
    input  logic [BYTE_W-1:0] a_hi,
    input  logic [BYTE_W-1:0] a_mid,
    input  logic [BYTE_W-1:0] a_lo,
    input  logic [BYTE_W-1:0] dat,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    output logic              rx_we,
    output logic [1:0]        rx_slot,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int BIT_W = $clog2(BYTE_W);

    seq_state_t state, state_nx;

    logic [1:0]        wenc_q;
    logic [1:0]        rcnt_q;
    logic [CNT_W-1:0]  byte_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              gap_half;

    logic [CNT_W-1:0]  nw;
    logic [CNT_W-1:0]  last_idx;
    logic              start;
    logic              byte_end;
    logic              frame_end;

    assign nw        = wr_bytes(wenc_q);
    assign last_idx  = nw + CNT_W'(rcnt_q) - 1'b1;
    assign start     = ctl_we && (state == ST_IDLE) && (ctl_din[7:4] == START_KEY);
    assign byte_end  = (bit_idx == '0);
    assign frame_end = byte_end && (byte_idx == last_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_LEAD;
            ST_LEAD:  if (tick)  state_nx = ST_HIGH;
            ST_HIGH:  if (tick)  state_nx = frame_end ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick)  state_nx = ST_HIGH;
            ST_TRAIL: if (tick)  state_nx = ST_GAP;
            ST_GAP:   if (tick && gap_half) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wenc_q   <= '0;
            rcnt_q   <= '0;
            byte_idx <= '0;
            bit_idx  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            gap_half <= 1'b0;
        end else if (start) begin
            wenc_q   <= ctl_din[1:0];
            rcnt_q   <= ctl_din[3:2];
            byte_idx <= '0;
            bit_idx  <= BIT_W'(BYTE_W - 1);
            tx_sh    <= op;
            rx_sh    <= '0;
            gap_half <= 1'b0;
        end else if (tick) begin
            unique case (state)
                ST_LEAD, ST_LOW: rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                ST_HIGH: begin
                    if (!byte_end) begin
                        bit_idx <= bit_idx - 1'b1;
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end else if (!frame_end) begin
                        byte_idx <= byte_idx + 1'b1;
                        bit_idx  <= BIT_W'(BYTE_W - 1);
                        tx_sh    <= tx_pick(byte_idx + 1'b1, wenc_q, op, a_hi, a_mid, a_lo, dat);
                    end
                end
                ST_GAP:  gap_half <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        sck     = (state == ST_HIGH);
        cs_n    = !((state == ST_LEAD) || (state == ST_HIGH) ||
                    (state == ST_LOW)  || (state == ST_TRAIL));
        mosi    = cs_n ? 1'b0 : tx_sh[BYTE_W-1];
        rx_we   = (state == ST_HIGH) && tick && byte_end && (byte_idx >= nw);
        rx_slot = 2'(byte_idx - nw);
        rx_byte = rx_sh;
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              busy_w;
    logic              tick_w;
    logic              rx_we_w;
    logic [1:0]        rx_slot_w;
    logic [BYTE_W-1:0] rx_byte_w;
    logic [BYTE_W-1:0] opcode_w, a_hi_w, a_mid_w, a_lo_w, dat_w;
    logic              ctl_we_w;

    assign ctl_we_w = wr_en && (wr_addr == OFS_CTL);

    spi_cmd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_w),
        .tick (tick_w)
    );

    spi_cmd_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_we  (wr_en),
        .host_addr(wr_addr),
        .host_din (wr_data),
        .busy     (busy_w),
        .rx_we    (rx_we_w),
        .rx_slot  (rx_slot_w),
        .rx_byte  (rx_byte_w),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .op_q     (opcode_w),
        .a_hi_q   (a_hi_w),
        .a_mid_q  (a_mid_w),
        .a_lo_q   (a_lo_w),
        .dat_q    (dat_w)
    );

    spi_cmd_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_w),
        .ctl_we (ctl_we_w),
        .ctl_din(wr_data),
        .miso   (spi_miso),
        .op     (opcode_w),
        .a_hi   (a_hi_w),
        .a_mid  (a_mid_w),
        .a_lo   (a_lo_w),
        .dat    (dat_w),
        .busy   (busy_w),
        .sck    (spi_sck),
        .cs_n   (spi_cs_n),
        .mosi   (spi_mosi),
        .rx_we  (rx_we_w),
        .rx_slot(rx_slot_w),
        .rx_byte(rx_byte_w)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi,
    input logic       busy,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] op_q
);
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R6

    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi)); // R6

    AST_CS_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R7

    AST_GAP_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> busy); // R8

    AST_OPCODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == 3'd1) |=> $stable(op_q)); // R9

endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck    (spi_sck),
    .cs_n   (spi_cs_n),
    .mosi   (spi_mosi),
    .busy   (busy_w),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .op_q   (opcode_w)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_cmd_engine #(.HALF_DIV(HALF)) u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash slave model
    logic [63:0] cap;
    logic [63:0] resp_stream = '0;
    int          mbits = 0;
    int          stray = 0;

    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (spi_sck) begin
            if (spi_cs_n) stray = stray + 1;
            cap   = {cap[62:0], spi_mosi};
            mbits = mbits + 1;
        end else begin
            cap   = '0;
            mbits = 0;
        end
    end

    assign spi_miso = (mbits < 64) ? resp_stream[63 - mbits] : 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // starts a frame and waits for busy to clear; returns gap cycles
    task automatic run_ctl(input logic [7:0] ctl, output int gap);
        logic [7:0] v;
        int guard;
        gap = 0;
        guard = 0;
        host_wr(3'd0, ctl);
        host_rd(3'd0, v);
        check(v == 8'h80, "R1 busy set after start", v, 8'h80);
        while (rd_data[7] && guard < 5000) begin
            @(negedge clk);
            #1;
            if (spi_cs_n && rd_data[7]) gap++;
            guard++;
        end
        host_rd(3'd0, v);
        check(v == 8'h00, "R1 busy clear at end", v, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            host_rd(3'(a), v);
            check(v == 8'h00, "R10 register after reset", v, 8'h00);
        end
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10 pins after reset", {spi_cs_n, spi_sck}, 2'b10);
    endtask

    task automatic t_frame(input string tag, input logic [1:0] wl, input logic [1:0] rl,
                           input logic [7:0] op, input logic [7:0] a4, input logic [7:0] a3,
                           input logic [7:0] a2, input logic [7:0] d,
                           input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2);
        logic [7:0] o5, o6, v;
        logic [63:0] exp;
        int nw, nbits, gap;
        nw = (wl == 0) ? 1 : (wl == 1) ? 2 : (wl == 2) ? 4 : 5;
        host_wr(3'd1, op); host_wr(3'd4, a4); host_wr(3'd3, a3);
        host_wr(3'd2, a2); host_wr(3'd7, d);
        host_rd(3'd5, o5); host_rd(3'd6, o6);
        resp_stream = {r0, r1, r2, 40'h0} >> (nw * 8);
        exp = {56'h0, op};
        if (wl[1]) begin
            exp = (exp << 8) | a4; exp = (exp << 8) | a3; exp = (exp << 8) | a2;
        end
        if (wl[0]) exp = (exp << 8) | d;
        exp = exp << (8 * int'(rl));
        nbits = 8 * (nw + int'(rl));
        stray = 0;
        run_ctl({4'h5, rl, wl}, gap);
        $display("scenario %s", tag);
        check(mbits == nbits, "R7 rising edge count", mbits, nbits);
        check(cap == exp, "R3 wire byte order", cap, exp);
        check(stray == 0, "R6 SCK quiet with CS high", stray, 0);
        check(gap == 2 * HALF, "R8 idle gap length", gap, 2 * HALF);
        host_rd(3'd5, v);
        check(v == ((rl >= 1) ? r0 : o5), "R4 R5 offset 5", v, (rl >= 1) ? r0 : o5);
        host_rd(3'd6, v);
        check(v == ((rl >= 2) ? r1 : o6), "R4 R5 offset 6", v, (rl >= 2) ? r1 : o6);
        host_rd(3'd7, v);
        check(v == ((rl == 3) ? r2 : d), "R4 shared offset 7", v, (rl == 3) ? r2 : d);
    endtask

    task automatic t_bad_key();
        logic [7:0] v;
        host_wr(3'd0, 8'h3F);
        for (int i = 0; i < 10; i++) begin
            host_rd(3'd0, v);
            check(v == 8'h00 && spi_cs_n, "R2 wrong key ignored", {v, spi_cs_n}, 9'h001);
            @(negedge clk);
        end
    endtask

    task automatic t_busy_writes();
        logic [7:0] v;
        int guard;
        host_wr(3'd1, 8'h06);
        resp_stream = '0;
        host_wr(3'd0, 8'h50);
        host_wr(3'd1, 8'hAA);
        host_wr(3'd0, 8'h5F);
        host_wr(3'd4, 8'hBB);
        guard = 0;
        host_rd(3'd0, v);
        while (v[7] && guard < 5000) begin
            @(negedge clk); host_rd(3'd0, v); guard++;
        end
        repeat (6) @(negedge clk);
        host_rd(3'd0, v);
        check(v == 8'h00 && spi_cs_n, "R9 no restart from busy write", {v, spi_cs_n}, 9'h001);
        check(mbits == 8 && cap == 64'h06, "R9 frame unchanged", cap, 64'h06);
        host_rd(3'd1, v);
        check(v == 8'h06, "R9 opcode kept", v, 8'h06);
        host_rd(3'd4, v);
        check(v == 8'h44, "R9 address kept", v, 8'h44);
    endtask

    task automatic t_readonly();
        logic [7:0] v5, v6, v;
        host_rd(3'd5, v5); host_rd(3'd6, v6);
        host_wr(3'd5, 8'hEE); host_wr(3'd6, 8'hEE);
        host_rd(3'd5, v);
        check(v == v5, "R11 offset 5 read-only", v, v5);
        host_rd(3'd6, v);
        check(v == v6, "R11 offset 6 read-only", v, v6);
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame("id-read",    2'd0, 2'd3, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h11, 8'hEF, 8'h40, 8'h17);
        t_frame("op+data",    2'd1, 2'd0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h00);
        t_frame("op+addr",    2'd2, 2'd2, 8'h03, 8'h12, 8'h34, 8'h56, 8'h77, 8'hA5, 8'h5A, 8'hFF);
        t_frame("op+addr+d",  2'd3, 2'd1, 8'h02, 8'hC1, 8'hD2, 8'hE3, 8'h99, 8'h81, 8'h00, 8'h00);
        t_frame("op only",    2'd0, 2'd0, 8'h06, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        t_bad_key();
        t_busy_writes();
        t_readonly();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule